// File: doc/BRIEF.md
# Strobe Delay Tap Centring Calibrator

This block searches for the centre of the window of good settings of a data-strobe delay line. A single pulse on `cal_start` begins a sweep. The block applies every tap setting in turn, always driving the same value on both byte lanes. After each tap change it waits a settle time, then starts an external self-test engine. It holds the test request until the engine reports completion and then judges the returned compare count.

Over the sweep the block keeps three things: the lowest passing tap, the highest passing tap, and a count of the passing taps. When the last tap has been tested, it programs the integer midpoint of the lowest and highest passing taps. If no tap passed, it puts back the tap that was applied before the sweep began. Completion is signalled by a one-cycle pulse on `cal_done`. The number of passing taps stays visible on `pass_count` until the next sweep starts.

Top module: `dqs_tap_calib`

## Requirements
- R1: A sweep applies tap values 0, 1, 2 … 63 in ascending order and launches exactly one self-test per value, 64 launches in all.
- R2: `tap_lane0` and `tap_lane1` always carry the same value: during the sweep, at the end of it, and when idle.
- R3: A tap passes only when the 8-bit `bist_cmp_cnt`, sampled in the cycle `bist_done` is high, equals 8 exactly. Values such as 9 or 0x88 fail.
- R4: `pass_count` (7 bits) is cleared when a sweep starts and rises by one for every passing tap, including passing taps that come after a failing gap. It holds its final value until the next sweep starts.
- R5: When at least one tap passed, the final tap equals (lowest passing + highest passing) / 2 with integer division, reduced modulo 64.
- R6: When no tap passed, the final tap is the value present on the lanes just before the sweep started. After reset that value is the parameter `TAP_RESET` (default 16).
- R7: `bist_start` stays high from launch until `bist_done` is seen, and is low in the following cycle. The tap does not change while a test is outstanding.
- R8: After every tap change, `bist_start` rises no earlier than `SETTLE_CYC`+1 clock cycles later (default `SETTLE_CYC` = 4).
- R9: `cal_done` is high for exactly one cycle, one cycle after the final tap is written. The lanes already show the final tap when `cal_done` is high.
- R10: A `cal_start` pulse that arrives while a sweep is in progress has no effect. The sweep keeps its order, its launch count and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Pulse to begin a sweep (ignored while busy) |
| cal_done | output | 1 | One-cycle pulse when the final tap is in place |
| tap_lane0 | output | 6 | Delay tap for byte lane 0 |
| tap_lane1 | output | 6 | Delay tap for byte lane 1 |
| bist_start | output | 1 | Request to the self-test engine |
| bist_done | input | 1 | Self-test completion |
| bist_cmp_cnt | input | 8 | Compare count returned by the self-test |
| pass_count | output | 7 | Number of passing taps in the latest sweep |

## Verification
The bench goes after the cases where an off-by-one or a wrong marker update would show up. These are a window that reaches tap 63, a single pass at tap 0 or tap 63, two windows split by a gap, and every tap passing. A design that moved the lowest marker on later passes, or stopped counting after a gap, would program the wrong midpoint or report the wrong count. Empty sweeps are run both straight after reset and after an earlier result. A design that restored a constant instead of the pre-sweep tap would fail the second case. Near-miss compare counts (9, 0x88) must be rejected. A mid-sweep `cal_start` must not restart the walk, or the launch order and count would break.

// File: rtl/dqs_cal_pkg.sv
// Shared types and helpers for the strobe delay tap calibrator.
// Assumes tap widths of at most 7 bits so the midpoint sum fits in 8 bits.
package dqs_cal_pkg;

    typedef enum logic [2:0] {
        CAL_IDLE,
        CAL_SETTLE,
        CAL_LAUNCH,
        CAL_FINISH,
        CAL_DONE
    } cal_state_t;

    // Integer midpoint of two taps, wrapped to the tap range given by width.
    function automatic logic [7:0] tap_midpoint(input logic [7:0] lo,
                                                input logic [7:0] hi,
                                                input int unsigned width);
        logic [8:0] sum;
        logic [7:0] mask;
        sum  = {1'b0, lo} + {1'b0, hi};
        mask = 8'((9'd1 << width) - 9'd1);
        return sum[8:1] & mask;
    endfunction

endpackage

// File: rtl/settle_timer.sv
// Down-counter that counts out the settle time after a tap change.
// Assumes load and count are not needed in the same cycle; expired is
// high whenever the count has reached zero.
module settle_timer #(
    parameter int CYC = 4,
    localparam int W = $clog2(CYC + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [W-1:0] cnt_q;

    // Reload on a tap change, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= W'(CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tap_window_tracker.sv
// Records the lowest and highest passing taps and counts the passes.
// Assumes taps are presented in ascending order, so the first pass seen
// is the lowest and each later pass becomes the new highest.
module tap_window_tracker #(
    parameter int TAP_W = 6,
    localparam int CNT_W = TAP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hit,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] lo_tap,
    output logic [TAP_W-1:0] hi_tap,
    output logic [CNT_W-1:0] hits,
    output logic             seen
);
    // Markers: a flag stands in for "no pass yet" instead of a magic value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo_tap <= '0;
            hi_tap <= '0;
            seen   <= 1'b0;
        end else if (hit) begin
            if (!seen) lo_tap <= tap;
            hi_tap <= tap;
            seen   <= 1'b1;
        end
    end

    // Pass counter, bumped on every pass including those after a gap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hits <= '0;
        else if (hit)        hits <= hits + 1'b1;
    end
endmodule

// File: rtl/dqs_tap_calib.sv
// Sweeps a shared delay tap over its full range, runs one external
// self-test per tap, and programs the centre of the passing window.
// Assumes the self-test engine holds bist_done until bist_start drops,
// and that bist_cmp_cnt is valid while bist_done is high.
module dqs_tap_calib
    import dqs_cal_pkg::*;
#(
    parameter int          TAP_W      = 6,
    parameter int          CMP_W      = 8,
    parameter int          EXP_CMP    = 8,
    parameter int          SETTLE_CYC = 4,
    parameter int          TAP_RESET  = 16,
    localparam int         PASS_W     = TAP_W + 1,
    localparam logic [TAP_W-1:0] TAP_LAST = {TAP_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    output logic              cal_done,
    output logic [TAP_W-1:0]  tap_lane0,
    output logic [TAP_W-1:0]  tap_lane1,
    output logic              bist_start,
    input  logic              bist_done,
    input  logic [CMP_W-1:0]  bist_cmp_cnt,
    output logic [PASS_W-1:0] pass_count
);
    cal_state_t       state_q;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] saved_q;
    logic [TAP_W-1:0] lo_tap, hi_tap;
    logic             seen;
    logic             settled;
    logic             begin_sweep, test_end, tap_hit, timer_load;
    logic [TAP_W-1:0] centre;

    assign begin_sweep = (state_q == CAL_IDLE) && cal_start;
    assign test_end    = (state_q == CAL_LAUNCH) && bist_done;
    assign tap_hit     = test_end && (bist_cmp_cnt == CMP_W'(EXP_CMP));
    assign timer_load  = begin_sweep || (test_end && tap_q != TAP_LAST);
    assign centre      = TAP_W'(tap_midpoint(8'(lo_tap), 8'(hi_tap), TAP_W));

    settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .expired (settled)
    );

    tap_window_tracker #(.TAP_W(TAP_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (begin_sweep),
        .hit    (tap_hit),
        .tap    (tap_q),
        .lo_tap (lo_tap),
        .hi_tap (hi_tap),
        .hits   (pass_count),
        .seen   (seen)
    );

    // Sweep sequencer: owns the tap register and the saved pre-sweep tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            tap_q   <= TAP_W'(TAP_RESET);
            saved_q <= TAP_W'(TAP_RESET);
        end else begin
            unique case (state_q)
                CAL_IDLE: if (cal_start) begin
                    saved_q <= tap_q;
                    tap_q   <= '0;
                    state_q <= CAL_SETTLE;
                end
                CAL_SETTLE: if (settled) state_q <= CAL_LAUNCH;
                CAL_LAUNCH: if (bist_done) begin
                    if (tap_q == TAP_LAST) begin
                        state_q <= CAL_FINISH;
                    end else begin
                        tap_q   <= tap_q + 1'b1;
                        state_q <= CAL_SETTLE;
                    end
                end
                CAL_FINISH: begin
                    tap_q   <= seen ? centre : saved_q;
                    state_q <= CAL_DONE;
                end
                CAL_DONE: state_q <= CAL_IDLE;
                default:  state_q <= CAL_IDLE;
            endcase
        end
    end

    assign bist_start = (state_q == CAL_LAUNCH);
    assign cal_done   = (state_q == CAL_DONE);
    assign tap_lane0  = tap_q;
    assign tap_lane1  = tap_q;
endmodule

// File: rtl/dqs_tap_calib_chk.sv
// Property checker for the tap calibrator, attached by bind.
// Assumes it sees the top-level ports only.
module dqs_tap_calib_chk #(
    parameter int TAP_W  = 6,
    parameter int PASS_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_done,
    input logic [TAP_W-1:0]  tap_lane0,
    input logic [TAP_W-1:0]  tap_lane1,
    input logic              bist_start,
    input logic              bist_done,
    input logic [PASS_W-1:0] pass_count
);
    localparam logic [TAP_W-1:0] TOP_TAP = {TAP_W{1'b1}};

    a_r2_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
        tap_lane0 == tap_lane1);

    a_r7_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_start && bist_done) |=> !bist_start);

    a_r7_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_start && !bist_done) |=> $stable(tap_lane0));

    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_start && bist_done && tap_lane0 != TOP_TAP)
        |=> tap_lane0 == $past(tap_lane0) + 1'b1);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    a_r9_tap_settled: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> $stable(tap_lane0));

    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        pass_count <= PASS_W'(1 << TAP_W));
endmodule

bind dqs_tap_calib dqs_tap_calib_chk #(.TAP_W(TAP_W), .PASS_W(PASS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_done   (cal_done),
    .tap_lane0  (tap_lane0),
    .tap_lane1  (tap_lane1),
    .bist_start (bist_start),
    .bist_done  (bist_done),
    .pass_count (pass_count)
);

// File: tb/tb_dqs_tap_calib.sv
module tb_dqs_tap_calib;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int BIST_LAT   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic       cal_done;
    logic [5:0] tap_lane0, tap_lane1;
    logic       bist_start;
    logic       bist_done = 1'b0;
    logic [7:0] bist_cmp_cnt = 8'h00;
    logic [6:0] pass_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [63:0] pass_map = '0;
    int launches = 0;
    int next_tap = 0;
    int gap = 0;
    logic [5:0] prev_tap = 6'd0;
    logic prev_bs = 1'b0;
    logic prev_handshake = 1'b0;
    int bist_wait = 0;

    typedef struct packed {
        logic [63:0] mask;
        logic [5:0]  tap;
        logic [6:0]  cnt;
        logic        poke;
    } vec_t;

    // Expected results worked out by hand from R5/R6.
    localparam vec_t VEC [7] = '{
        '{64'h0,                   6'd16, 7'd0,  1'b0},  // R6 empty after reset
        '{64'h0000_0000_001F_FC00, 6'd15, 7'd11, 1'b1},  // taps 10..20, R10 poke
        '{64'h0,                   6'd15, 7'd0,  1'b0},  // R6 restore earlier result
        '{64'h0000_0300_0000_01E0, 6'd23, 7'd6,  1'b0},  // gap: 5..8 and 40..41
        '{64'h8000_0000_0000_0000, 6'd63, 7'd1,  1'b0},  // only tap 63
        '{64'hFFFF_FFFF_FFFF_FFFF, 6'd31, 7'd64, 1'b0},  // all pass
        '{64'h0000_0000_0000_0001, 6'd0,  7'd1,  1'b0}   // only tap 0
    };

    dqs_tap_calib dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_start),
        .cal_done     (cal_done),
        .tap_lane0    (tap_lane0),
        .tap_lane1    (tap_lane1),
        .bist_start   (bist_start),
        .bist_done    (bist_done),
        .bist_cmp_cnt (bist_cmp_cnt),
        .pass_count   (pass_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Self-test model and sweep monitor, all on the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (prev_handshake) check(!bist_start, "R7 start low after done", bist_start, 0);
        prev_handshake = bist_start && bist_done;
        if (tap_lane0 != tap_lane1) check(0, "R2 lanes differ", tap_lane1, tap_lane0);
        if (tap_lane0 != prev_tap) gap = 1; else gap++;
        if (bist_start && !prev_bs) begin
            launches++;
            if (tap_lane0 != 6'(next_tap)) check(0, "R1 tap order", tap_lane0, next_tap);
            if (gap < SETTLE + 1) check(0, "R8 settle gap", gap, SETTLE + 1);
            next_tap++;
        end
        if (bist_start && bist_done && bist_wait == 0)
            check(0, "R7 tap moved during test", tap_lane0, prev_tap);
        prev_tap = tap_lane0;
        prev_bs  = bist_start;
        if (!bist_start) begin
            bist_done = 1'b0;
            bist_wait = 0;
        end else if (!bist_done) begin
            bist_wait++;
            if (bist_wait == BIST_LAT) begin
                bist_done = 1'b1;
                bist_wait = 0;
                if (pass_map[tap_lane0]) bist_cmp_cnt = 8'd8;
                else bist_cmp_cnt = tap_lane0[0] ? 8'd9 : 8'h88;  // R3 near misses
            end
        end
    end

    task automatic run_sweep(input vec_t v);
        int wait_cnt;
        pass_map = v.mask;
        launches = 0;
        next_tap = 0;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        wait_cnt = 0;
        while (!cal_done && wait_cnt < 5000) begin
            @(negedge clk);
            wait_cnt++;
            if (v.poke && wait_cnt == 150) cal_start = 1'b1;  // R10
            else cal_start = 1'b0;
        end
        check(cal_done, "R9 done seen", cal_done, 1);
        check(launches == 64, "R1 launch count", launches, 64);
        check(tap_lane0 == v.tap, "R5/R6 final tap lane0", tap_lane0, v.tap);
        check(tap_lane1 == v.tap, "R2 final tap lane1", tap_lane1, v.tap);
        check(pass_count == v.cnt, "R4 pass count", pass_count, v.cnt);
        @(negedge clk);
        check(!cal_done, "R9 done one cycle", cal_done, 0);
        repeat (3) @(negedge clk);
        check(pass_count == v.cnt, "R4 count held", pass_count, v.cnt);
        check(tap_lane0 == v.tap, "R9 tap held", tap_lane0, v.tap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tap_lane0 == 6'd16, "R6 reset tap", tap_lane0, 16);
        check(tap_lane1 == 6'd16, "R2 reset lane1", tap_lane1, 16);
        check(!bist_start, "R7 reset bist idle", bist_start, 0);
        check(!cal_done, "R9 reset done low", cal_done, 0);
        check(pass_count == 0, "R4 reset count", pass_count, 0);
        for (int i = 0; i < 7; i++) run_sweep(VEC[i]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        check(0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule